// File: doc/BRIEF.md
# Multiplier-Based Shift and Magnitude Unit

This block gets left shifts, absolute value and two's-complement negation out of one signed 18 by 18 multiplier. The data word always goes in as the first factor. The operation select and the shift count pick the second factor. A power of two gives a shift. Plus or minus one, taken from the data's own sign, gives the magnitude. All ones, which is minus one, gives the negation. No mux tree or adder is placed in the result path.

Both shift modes, logical and arithmetic, accept counts from 0 to 16. The second factor cannot use its sign bit, so a weight of 2^17 cannot be formed. A larger count is flagged and the result is forced to zero. The 36-bit result is read according to the mode that produced it. An output stage with a clock enable and a synchronous reset adds one cycle of latency.

Top module: `smu_shift_abs_unit`

## Requirements
- R1: With op_sel = 2'b00 (logical), res_o equals data bits 16:0, zero-extended to 36 bits and shifted left by shamt_i. Data bit 17 is ignored.
- R2: With op_sel = 2'b01 (arithmetic), res_o equals the 18-bit signed data, sign-extended to 36 bits and shifted left by shamt_i. Bits below the shifted data are zero and bits above it copy data bit 17.
- R3: In both shift modes, shamt_i values 0 to 16 are legal. A value of 17 or more sets range_err_o to 1 and forces res_o to zero.
- R4: With op_sel = 2'b10 (magnitude), res_o[16:0] holds the low 17 bits of the absolute value of the signed data, and res_o[35:17] is zero. An input of -131072 therefore yields zero.
- R5: With op_sel = 2'b11 (negate), res_o[17:0] holds the 18-bit two's complement of the data, and res_o[35:18] is zero.
- R6: In op_sel 2'b10 and 2'b11, shamt_i has no effect and range_err_o is 0.
- R7: A result appears on res_o and range_err_o after the first rising clock edge at which en_i is 1 with the operands applied.
- R8: While en_i is 0, res_o and range_err_o hold their values.
- R9: rst_i is synchronous, active high, and overrides en_i. After an edge with rst_i high, res_o is zero and range_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Clock enable for the output stage |
| data_i | input | 18 | Data word, the first factor |
| shamt_i | input | 5 | Left-shift count for the shift modes |
| op_sel_i | input | 2 | 00 logical shift, 01 arithmetic shift, 10 magnitude, 11 negate |
| res_o | output | 36 | Result, read per mode |
| range_err_o | output | 1 | Shift count above 16 in a shift mode |

## Verification
Every result, including the range flag and the reset value, is due one rising edge after its operands are presented with en_i high. The bench changes inputs on the falling edge, so each result is sampled on the next falling edge, half a period after the edge that loaded it. For the hold check, the inputs change with en_i low, and the output is sampled on the falling edge after the rising edge that ignored them, then compared with the previous result.

// File: rtl/smu_pkg.sv
package smu_pkg;

    // Operation select; the shift/non-shift split (bit 1) is decoded downstream
    typedef enum logic [1:0] {
        SMU_SHL_LOGIC = 2'b00,
        SMU_SHL_ARITH = 2'b01,
        SMU_MAGNITUDE = 2'b10,
        SMU_NEGATE    = 2'b11
    } smu_op_e;

    function automatic logic smu_is_shift(smu_op_e op);
        return (op == SMU_SHL_LOGIC) || (op == SMU_SHL_ARITH);
    endfunction

endpackage

// File: rtl/smu_operand_gen.sv
module smu_operand_gen
    import smu_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int SHIFT_W = 5
) (
    input  logic [DATA_W-1:0]  data_i,
    input  logic [SHIFT_W-1:0] shamt_i,
    input  smu_op_e            op_i,
    output logic [DATA_W-1:0]  fac_a_o,
    output logic [DATA_W-1:0]  fac_b_o,
    output logic               range_err_o
);

    // Sign bit of the second factor is unusable for a power of two
    localparam int MAX_SHIFT = DATA_W - 2;
    localparam logic [SHIFT_W-1:0] MAX_SHIFT_V = SHIFT_W'(MAX_SHIFT);

    logic [DATA_W-1:0] pow2_w;
    logic              over_w;

    // One-hot decoder of the shift count onto the usable magnitude bits
    for (genvar i = 0; i <= MAX_SHIFT; i++) begin : g_pow2
        assign pow2_w[i] = (shamt_i == SHIFT_W'(i));
    end
    assign pow2_w[DATA_W-1] = 1'b0;

    assign over_w = shamt_i > MAX_SHIFT_V;

    always_comb begin
        fac_a_o     = data_i;
        fac_b_o     = '0;
        range_err_o = 1'b0;
        unique case (op_i)
            SMU_SHL_LOGIC: begin
                fac_a_o     = {1'b0, data_i[DATA_W-2:0]};
                fac_b_o     = over_w ? '0 : pow2_w;
                range_err_o = over_w;
            end
            SMU_SHL_ARITH: begin
                fac_b_o     = over_w ? '0 : pow2_w;
                range_err_o = over_w;
            end
            SMU_MAGNITUDE: begin
                fac_b_o = {{(DATA_W-1){data_i[DATA_W-1]}}, 1'b1};
            end
            SMU_NEGATE: begin
                fac_b_o = '1;
            end
            default: begin
                fac_b_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/smu_mult_core.sv
module smu_mult_core #(
    parameter int DATA_W = 18
) (
    input  logic [DATA_W-1:0]   fac_a_i,
    input  logic [DATA_W-1:0]   fac_b_i,
    output logic [2*DATA_W-1:0] prod_o
);

    logic signed [DATA_W-1:0]   a_s;
    logic signed [DATA_W-1:0]   b_s;
    logic signed [2*DATA_W-1:0] p_s;

    assign a_s    = signed'(fac_a_i);
    assign b_s    = signed'(fac_b_i);
    assign p_s    = a_s * b_s;
    assign prod_o = unsigned'(p_s);

endmodule

// File: rtl/smu_result_fmt.sv
module smu_result_fmt
    import smu_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic [2*DATA_W-1:0] prod_i,
    input  smu_op_e             op_i,
    input  logic                range_err_i,
    output logic [2*DATA_W-1:0] res_o
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int MAG_W  = DATA_W - 1;

    always_comb begin
        res_o = '0;
        unique case (op_i)
            SMU_SHL_LOGIC,
            SMU_SHL_ARITH: res_o = range_err_i ? '0 : prod_i;
            SMU_MAGNITUDE: res_o = {{(PROD_W-MAG_W){1'b0}}, prod_i[MAG_W-1:0]};
            SMU_NEGATE:    res_o = {{(PROD_W-DATA_W){1'b0}}, prod_i[DATA_W-1:0]};
            default:       res_o = '0;
        endcase
    end

endmodule

// File: rtl/smu_shift_abs_unit.sv
module smu_shift_abs_unit
    import smu_pkg::*;
#(
    parameter int DATA_W     = 18,
    parameter int SHIFT_W    = 5,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                en_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic [SHIFT_W-1:0]  shamt_i,
    input  logic [1:0]          op_sel_i,
    output logic [2*DATA_W-1:0] res_o,
    output logic                range_err_o
);

    localparam int PROD_W = 2 * DATA_W;

    typedef struct packed {
        logic [PROD_W-1:0] res;
        logic              err;
    } stage_t;

    smu_op_e           op_w;
    logic [DATA_W-1:0] fac_a_w;
    logic [DATA_W-1:0] fac_b_w;
    logic [PROD_W-1:0] prod_w;
    logic [PROD_W-1:0] fmt_w;
    logic              err_w;

    assign op_w = smu_op_e'(op_sel_i);

    smu_operand_gen #(
        .DATA_W  (DATA_W),
        .SHIFT_W (SHIFT_W)
    ) i_operand_gen (
        .data_i      (data_i),
        .shamt_i     (shamt_i),
        .op_i        (op_w),
        .fac_a_o     (fac_a_w),
        .fac_b_o     (fac_b_w),
        .range_err_o (err_w)
    );

    smu_mult_core #(
        .DATA_W (DATA_W)
    ) i_mult_core (
        .fac_a_i (fac_a_w),
        .fac_b_i (fac_b_w),
        .prod_o  (prod_w)
    );

    smu_result_fmt #(
        .DATA_W (DATA_W)
    ) i_result_fmt (
        .prod_i      (prod_w),
        .op_i        (op_w),
        .range_err_i (err_w),
        .res_o       (fmt_w)
    );

    if (REGISTERED) begin : g_reg
        stage_t stage_d;
        stage_t stage_q;

        always_comb begin
            stage_d = stage_q;
            if (rst_i) begin
                stage_d = '0;
            end else if (en_i) begin
                stage_d.res = fmt_w;
                stage_d.err = err_w;
            end
        end

        always_ff @(posedge clk_i) begin
            stage_q <= stage_d;
        end

        assign res_o       = stage_q.res;
        assign range_err_o = stage_q.err;

        // R9
        reset_clear_chk: assert property (@(posedge clk_i)
            rst_i |=> (res_o == '0) && !range_err_o);

        // R8
        enable_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !en_i |=> $stable(res_o) && $stable(range_err_o));

        // R3
        err_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            range_err_o |-> (res_o == '0));

        // R4
        mag_upper_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            en_i && (op_w == SMU_MAGNITUDE) |=> (res_o[PROD_W-1:DATA_W-1] == '0));

        // R5
        neg_upper_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            en_i && (op_w == SMU_NEGATE) |=> (res_o[PROD_W-1:DATA_W] == '0));

        // R6
        nonshift_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            en_i && !smu_is_shift(op_w) |=> !range_err_o);

        // R1
        shift_factor_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            smu_is_shift(op_w) |-> $onehot0(fac_b_w) && (fac_b_w[DATA_W-1] == 1'b0));
    end else begin : g_comb
        assign res_o       = fmt_w;
        assign range_err_o = err_w;
    end

endmodule

// File: tb/test_smu_shift_abs_unit.sv
module test_smu_shift_abs_unit;

    localparam time HALF = 5ns;

    logic        clk_i = 1'b0;
    logic        rst_i;
    logic        en_i;
    logic [17:0] data_i;
    logic [4:0]  shamt_i;
    logic [1:0]  op_sel_i;
    logic [35:0] res_o;
    logic        range_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #HALF clk_i = ~clk_i;

    smu_shift_abs_unit i_smu_shift_abs_unit (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_i        (en_i),
        .data_i      (data_i),
        .shamt_i     (shamt_i),
        .op_sel_i    (op_sel_i),
        .res_o       (res_o),
        .range_err_o (range_err_o)
    );

    function automatic logic exp_err(logic [4:0] n, logic [1:0] m);
        return (m[1] == 1'b0) && (n > 5'd16);
    endfunction

    function automatic logic [35:0] exp_res(logic [17:0] d, logic [4:0] n, logic [1:0] m);
        logic signed [35:0] sx;
        logic signed [35:0] mag;
        logic [35:0] t;
        sx = {{18{d[17]}}, d};
        if (m[1] == 1'b0 && n > 5'd16) return 36'd0;
        case (m)
            2'b00: t = {19'd0, d[16:0]} << n;
            2'b01: t = sx << n;
            2'b10: begin
                mag = (sx < 0) ? -sx : sx;
                t = {19'd0, mag[16:0]};
            end
            default: begin
                mag = -sx;
                t = {18'd0, mag[17:0]};
            end
        endcase
        return t;
    endfunction

    task automatic check(string req, logic [35:0] exp_r, logic exp_e);
        n_checks++;
        if (res_o !== exp_r || range_err_o !== exp_e) begin
            n_fail++;
            $display("FAIL %s: res=%h err=%b expected res=%h err=%b",
                     req, res_o, range_err_o, exp_r, exp_e);
        end
    endtask

    // Drive on falling edge, result due after next rising edge, sampled at following falling edge
    task automatic apply(string req, logic [17:0] d, logic [4:0] n, logic [1:0] m);
        data_i   = d;
        shamt_i  = n;
        op_sel_i = m;
        en_i     = 1'b1;
        @(negedge clk_i);
        check(req, exp_res(d, n, m), exp_err(n, m));
    endtask

    initial begin
        logic [35:0] held_r;
        logic        held_e;
        void'($urandom(32'd1234));
        rst_i = 1'b1; en_i = 1'b0; data_i = '0; shamt_i = '0; op_sel_i = '0;
        @(negedge clk_i);
        @(negedge clk_i);
        check("R9 reset", 36'd0, 1'b0);
        rst_i = 1'b0;

        // R1 logical shift: data bit 17 ignored
        apply("R1", 18'h3FFFF, 5'd0,  2'b00);
        apply("R1", 18'h3FFFF, 5'd16, 2'b00);
        apply("R1", 18'h00001, 5'd16, 2'b00);
        // R2 arithmetic shift with sign fill
        apply("R2", 18'h20000, 5'd16, 2'b01);
        apply("R2", 18'h3FFFF, 5'd5,  2'b01);
        apply("R2", 18'h1FFFF, 5'd16, 2'b01);
        // R3 out-of-range counts
        apply("R3", 18'h12345, 5'd17, 2'b00);
        apply("R3", 18'h2ABCD, 5'd31, 2'b01);
        // R4 magnitude
        apply("R4", 18'h20000, 5'd0,  2'b10);
        apply("R4", 18'h3FFFF, 5'd3,  2'b10);
        apply("R4", 18'h1FFFF, 5'd9,  2'b10);
        // R6 shamt has no effect outside shift modes
        apply("R6", 18'h2F00F, 5'd31, 2'b10);
        apply("R6", 18'h00077, 5'd20, 2'b11);
        // R5 negate
        apply("R5", 18'h00000, 5'd0,  2'b11);
        apply("R5", 18'h20000, 5'd0,  2'b11);
        apply("R5", 18'h00001, 5'd0,  2'b11);

        // R7 one-cycle latency: result after first enabled edge
        apply("R7", 18'h00003, 5'd4, 2'b00);

        // R8 hold while disabled
        held_r = res_o; held_e = range_err_o;
        en_i = 1'b0; data_i = 18'h2AAAA; shamt_i = 5'd25; op_sel_i = 2'b01;
        @(negedge clk_i);
        check("R8 hold", held_r, held_e);
        @(negedge clk_i);
        check("R8 hold", held_r, held_e);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [1:0] m;
            m = 2'($urandom_range(0, 3));
            apply(m == 2'b00 ? "R1 rand" : m == 2'b01 ? "R2 rand" :
                  m == 2'b10 ? "R4 rand" : "R5 rand",
                  18'($urandom), 5'($urandom_range(0, 20)), m);
        end

        // R9 reset overrides enable
        apply("R3", 18'h00005, 5'd18, 2'b00);
        rst_i = 1'b1; en_i = 1'b1; data_i = 18'h1FFFF; op_sel_i = 2'b01; shamt_i = 5'd3;
        @(negedge clk_i);
        check("R9 reset over enable", 36'd0, 1'b0);
        rst_i = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(HALF * 2 * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule